// File: doc/BRIEF.md
# Flash Converter Digital Back-End

This block is the digital half of a 128-comparator flash analog-to-digital converter. Each conversion clock period has two phases. While the clock is high the comparators are being zeroed. While the clock is low they are sampling, and their results reach the block as a 128-bit thermometer word, with bit 0 as the lowest threshold. The block captures that word when the clock falls into the low phase. It reduces the word to a 7-bit binary code plus an overflow flag. The result moves into an output register when the clock rises again. In continuous operation a new result therefore appears on every rising edge.

The encoder counts the unbroken run of set comparators starting at bit 0. Any isolated set bits above the first clear bit are ignored, so a malformed thermometer word can only shift the code downward to the real run length. When every comparator is set, the overflow flag rises and the seven data bits are all ones as well, giving 0xFF.

Two chip-select inputs control the output drivers. `cs_b` is the master enable. `cs_a` gives the overflow bit its own access path: when both selects are high, only the overflow bit drives. The tri-state drivers are modelled as separate enables for the data bus and the overflow bit. The registered values sit next to those enables.

The output-mode decoder has three named states:
- `OM_HIZ`: everything released.
- `OM_FULL`: data and overflow both driven.
- `OM_OVF_ONLY`: overflow driven, data released.

The decoder picks among them combinationally from the two selects:
- `cs_b` low gives `OM_HIZ`.
- `cs_b` high with `cs_a` low gives `OM_FULL`.
- `cs_b` high with `cs_a` high gives `OM_OVF_ONLY`.

Top module: `flash_backend`

## Requirements
- R1: With `rst` high at a rising edge, `code_q` becomes 0 and `ovf_q` becomes 0 after that edge.
- R2: A word with exactly k contiguous set bits from bit 0 and clear bits above, for k from 0 to 127, yields `code_q` = k and `ovf_q` = 0.
- R3: A word with all 128 bits set yields `ovf_q` = 1 and `code_q` = 127, so the 8-bit value {ovf_q, code_q} is 0xFF.
- R4: Set bits above the lowest clear bit are ignored. The code equals the index of the lowest clear bit, and overflow stays 0 whenever any bit is clear.
- R5: The word is captured at the falling clock edge. Its result appears on `code_q`/`ovf_q` after the next rising edge. Changes to `therm_in` after the falling edge do not alter that result.
- R6: Under continuous operation each rising edge presents the result of the word captured at the falling edge just before it.
- R7: With `cs_b` = 0, `code_oe` = 0 and `ovf_oe` = 0 whatever `cs_a` is.
- R8: With `cs_b` = 1 and `cs_a` = 0, `code_oe` = 1 and `ovf_oe` = 1.
- R9: With `cs_b` = 1 and `cs_a` = 1, `ovf_oe` = 1 and `code_oe` = 0.
- R10: The chip selects have no effect on the registered `code_q`/`ovf_q` values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; high = zeroing phase, low = sampling phase |
| rst | input | 1 | Synchronous active-high reset of both pipeline registers |
| therm_in | input | 128 | Comparator thermometer word, bit 0 = lowest threshold |
| cs_a | input | 1 | Select that releases the data bits while `cs_b` is high |
| cs_b | input | 1 | Master select for all output drivers |
| code_q | output | 7 | Registered binary code |
| ovf_q | output | 1 | Registered overflow flag |
| code_oe | output | 1 | Drive enable for the data bits |
| ovf_oe | output | 1 | Drive enable for the overflow bit |

## Verification
Clean thermometer words for every run length from 0 to 128 show that the code tracks the run length one-for-one. They include the carry from 63 to 64 and the jump to 0xFF at full scale. Bubble words have stray set bits above a gap: above an empty run, one below full scale, and directly under the overflow comparator. These separate a run-length encoder from a plain population count or a highest-set-bit search. After each falling edge the input is overwritten with garbage, which exposes any capture at the wrong edge. The four chip-select combinations are applied while a known value is held, to separate the asymmetric enable decode from any disturbance of the data path.

// File: rtl/flash_pkg.sv
package flash_pkg;
    // Default code width; the comparator count is two to this power.
    parameter int DEF_CODE_W = 7;

    // Output driver mode selected by the chip selects.
    typedef enum logic [1:0] {
        OM_HIZ      = 2'd0,
        OM_FULL     = 2'd1,
        OM_OVF_ONLY = 2'd2
    } out_mode_t;
endpackage

// File: rtl/flash_sample_latch.sv
module flash_sample_latch #(
    parameter int N_CMP = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CMP-1:0] therm_d,
    output logic [N_CMP-1:0] therm_q
);
    // Comparator states are frozen when the clock enters the sampling phase.
    always_ff @(negedge clk) begin
        if (rst) begin
            therm_q <= '0;
        end else begin
            therm_q <= therm_d;
        end
    end
endmodule

// File: rtl/flash_therm_encoder.sv
module flash_therm_encoder #(
    parameter int CODE_W = 7,
    localparam int N_CMP = 1 << CODE_W,
    localparam int CNT_W = CODE_W + 1
) (
    input  logic [N_CMP-1:0]  therm,
    output logic [CODE_W-1:0] code,
    output logic              ovf
);
    logic [CNT_W-1:0] run_len;

    // Length of the unbroken run of ones from bit 0 = index of lowest zero.
    always_comb begin
        run_len = CNT_W'(N_CMP);
        for (int i = N_CMP - 1; i >= 0; i--) begin
            if (!therm[i]) begin
                run_len = CNT_W'(i);
            end
        end
    end

    // Full run sets overflow and saturates the data bits to ones.
    always_comb begin
        ovf  = run_len[CODE_W];
        code = ovf ? {CODE_W{1'b1}} : run_len[CODE_W-1:0];
    end
endmodule

// File: rtl/flash_out_stage.sv
module flash_out_stage #(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_d,
    input  logic              ovf_d,
    output logic [CODE_W-1:0] code_q,
    output logic              ovf_q
);
    // Result moves to the output register on return to the zeroing phase.
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            code_q <= code_d;
            ovf_q  <= ovf_d;
        end
    end
endmodule

// File: rtl/flash_oe_decode.sv
module flash_oe_decode
    import flash_pkg::*;
(
    input  logic cs_a,
    input  logic cs_b,
    output logic code_oe,
    output logic ovf_oe
);
    out_mode_t mode;

    // Mode selection from the chip selects.
    always_comb begin
        if (!cs_b) begin
            mode = OM_HIZ;
        end else if (cs_a) begin
            mode = OM_OVF_ONLY;
        end else begin
            mode = OM_FULL;
        end
    end

    // Driver enables per mode.
    always_comb begin
        unique case (mode)
            OM_HIZ: begin
                code_oe = 1'b0;
                ovf_oe  = 1'b0;
            end
            OM_FULL: begin
                code_oe = 1'b1;
                ovf_oe  = 1'b1;
            end
            OM_OVF_ONLY: begin
                code_oe = 1'b0;
                ovf_oe  = 1'b1;
            end
            default: begin
                code_oe = 1'b0;
                ovf_oe  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/flash_backend.sv
module flash_backend #(
    parameter int CODE_W = flash_pkg::DEF_CODE_W,
    localparam int N_CMP = 1 << CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CMP-1:0]  therm_in,
    input  logic              cs_a,
    input  logic              cs_b,
    output logic [CODE_W-1:0] code_q,
    output logic              ovf_q,
    output logic              code_oe,
    output logic              ovf_oe
);
    logic [N_CMP-1:0]  therm_held;
    logic [CODE_W-1:0] enc_code;
    logic              enc_ovf;

    flash_sample_latch #(.N_CMP(N_CMP)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .therm_d (therm_in),
        .therm_q (therm_held)
    );

    flash_therm_encoder #(.CODE_W(CODE_W)) u_enc (
        .therm (therm_held),
        .code  (enc_code),
        .ovf   (enc_ovf)
    );

    flash_out_stage #(.CODE_W(CODE_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .code_d (enc_code),
        .ovf_d  (enc_ovf),
        .code_q (code_q),
        .ovf_q  (ovf_q)
    );

    flash_oe_decode u_oe (
        .cs_a    (cs_a),
        .cs_b    (cs_b),
        .code_oe (code_oe),
        .ovf_oe  (ovf_oe)
    );
endmodule

// File: rtl/flash_backend_chk.sv
module flash_backend_chk #(
    parameter int CODE_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_a,
    input logic              cs_b,
    input logic [CODE_W-1:0] code_q,
    input logic              ovf_q,
    input logic              code_oe,
    input logic              ovf_oe
);
    // R1: first edge after reset releases shows a cleared result
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (code_q == '0 && !ovf_q));

    // R3: overflow never appears without saturated data bits
    p_ovf_full_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> (&code_q));

    // R7: master select low releases every driver
    p_bus_off_r7: assert property (@(posedge clk) disable iff (rst)
        !cs_b |-> (!code_oe && !ovf_oe));

    // R8: master select high with cs_a low drives everything
    p_full_drive_r8: assert property (@(posedge clk) disable iff (rst)
        (cs_b && !cs_a) |-> (code_oe && ovf_oe));

    // R9: both selects high drives overflow only
    p_ovf_only_r9: assert property (@(posedge clk) disable iff (rst)
        (cs_b && cs_a) |-> (ovf_oe && !code_oe));
endmodule

bind flash_backend flash_backend_chk #(.CODE_W(CODE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_a    (cs_a),
    .cs_b    (cs_b),
    .code_q  (code_q),
    .ovf_q   (ovf_q),
    .code_oe (code_oe),
    .ovf_oe  (ovf_oe)
);

// File: tb/flash_backend_tb_top.sv
module flash_backend_tb_top;
    localparam int CODE_W = 7;
    localparam int N_CMP  = 1 << CODE_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_CMP-1:0]  therm_in = '0;
    logic              cs_a = 1'b0;
    logic              cs_b = 1'b1;
    logic [CODE_W-1:0] code_q;
    logic              ovf_q;
    logic              code_oe;
    logic              ovf_oe;

    int n_cmp  = 0;
    int n_bad  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    flash_backend #(.CODE_W(CODE_W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .therm_in (therm_in),
        .cs_a     (cs_a),
        .cs_b     (cs_b),
        .code_q   (code_q),
        .ovf_q    (ovf_q),
        .code_oe  (code_oe),
        .ovf_oe   (ovf_oe)
    );

    always #10 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic logic [7:0] expect_k(int k);
        if (k >= N_CMP) return 8'hFF;
        return {1'b0, 7'(k)};
    endfunction

    function automatic logic [N_CMP-1:0] run_word(int k);
        if (k >= N_CMP) return '1;
        return (N_CMP'(1) << k) - N_CMP'(1);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: present a word during the zeroing phase, scribble after capture (R5).
    task automatic drive(logic [N_CMP-1:0] w, logic [7:0] exp, string tag);
        @(posedge clk);
        #2 therm_in = w;
        @(negedge clk);
        #2 therm_in = ~w;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: one result per rising edge (R6).
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), {ovf_q, code_q}, exp_q.pop_front());
            end
        end
    end

    task automatic check_oe(logic a, logic b, logic [7:0] held, string req,
                            logic e_code, logic e_ovf);
        @(negedge clk);
        #3 cs_a = a; cs_b = b;
        #2;
        check(req, {6'd0, code_oe, ovf_oe}, {6'd0, e_code, e_ovf});
        check("R10", {ovf_q, code_q}, held);
    endtask

    initial begin
        logic [N_CMP-1:0] w;
        repeat (3) @(posedge clk);
        #5 check("R1", {ovf_q, code_q}, 8'h00);
        @(posedge clk);
        #2 rst = 1'b0;

        // R2/R3: every run length, back to back
        for (int k = 0; k <= N_CMP; k++) begin
            drive(run_word(k), expect_k(k), (k == N_CMP) ? "R3" : "R2");
        end

        // R4: bubble words
        w = run_word(40); w[60:45] = '1;
        drive(w, expect_k(40), "R4");
        w = '0; w[5] = 1'b1;
        drive(w, expect_k(0), "R4");
        w = run_word(126); w[127] = 1'b1;
        drive(w, expect_k(126), "R4");
        w = run_word(63); w[127] = 1'b1;
        drive(w, expect_k(63), "R4");
        w = '1; w[0] = 1'b0;
        drive(w, expect_k(0), "R4");

        // R5: hold full scale and check select modes against it
        drive('1, 8'hFF, "R5");
        @(posedge clk);
        #2 therm_in = '1;
        @(posedge clk);
        check_oe(1'b0, 1'b0, 8'hFF, "R7", 1'b0, 1'b0);
        check_oe(1'b1, 1'b0, 8'hFF, "R7", 1'b0, 1'b0);
        check_oe(1'b0, 1'b1, 8'hFF, "R8", 1'b1, 1'b1);
        check_oe(1'b1, 1'b1, 8'hFF, "R9", 1'b0, 1'b1);

        // R1: reset mid-run clears the result
        @(posedge clk);
        #2 rst = 1'b1;
        @(posedge clk);
        #5 check("R1", {ovf_q, code_q}, 8'h00);
        #2 rst = 1'b0;
        drive(run_word(64), expect_k(64), "R6");

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule